// File: doc/BRIEF.md
# Latched Output Fault Supervisor

This block is the mode controller that sits beside the pulse-width loop of a synchronous step-down converter. It watches an active-high enable pin, the converter oscillator tick, and two digital flags from analog comparators: one that says the output has sagged below 70% of nominal, and one that says the output is more than 7% above its regulation point. From these it selects one of four modes and produces registered override signals for the gate-drive logic and an enable for the reference.

After enable, undervoltage protection stays blind for a fixed number of oscillator cycles, so that the output can ramp up. Once armed, a qualified undervoltage flag latches the converter off. A qualified overvoltage flag at any time during normal running latches a crowbar that holds the low-side switch on and the high-side switch off. Both fault modes can only be left through a fresh rising edge on the enable pin. While undervoltage lockout is held, the overvoltage flag is ignored.

Top module: `buck_fault_sup`

## Requirements
- R1: A synchronous reset puts the block in the off mode, with mode code 0. In the off mode the drive outputs are hs_force_off=1, ls_force_on=0, ls_force_off=1 and ref_en=0.
- R2: With the enable pin high, the block goes from off to the running mode (code 1) SYNC_STAGES+1 clock edges after the pin change. A low pin in the running mode returns the block to off after the same delay. In the running mode hs_force_off=0, ls_force_on=0, ls_force_off=0 and ref_en=1.
- R3: A fault flag acts only after it has been seen high on QUAL_DEPTH consecutive clock edges. The mode then changes on the edge that follows. A flag that is high for fewer edges has no effect.
- R4: The running mode counts oscillator ticks from the moment it is entered. A qualified undervoltage flag moves the block to undervoltage lockout (code 2) only on the edge after the ARM_CYCLES-th counted tick. Before that edge the flag has no effect.
- R5: Undervoltage lockout is latched. Outputs there are hs_force_off=1, ls_force_on=0, ls_force_off=1 and ref_en=0. A low enable pin does not release it. Only a low-to-high edge on the pin returns the block to running.
- R6: A qualified overvoltage flag in the running mode enters the crowbar mode (code 3), armed or not. Outputs there are hs_force_off=1, ls_force_on=1, ls_force_off=0 and ref_en=0.
- R7: The crowbar is latched. Neither removal of the flag nor a pin held high releases it, and a low pin does not release it either. Only a pin rising edge returns the block to running.
- R8: While in undervoltage lockout the overvoltage flag has no effect, and ls_force_on stays 0.
- R9: When both flags qualify on the same edge in an armed running mode, the crowbar wins.
- R10: The arming count restarts from zero on every entry to the running mode, including an entry out of a fault.
- R11: ls_force_on and ls_force_off are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_pin | input | 1 | Asynchronous enable pin, high to run |
| osc_tick | input | 1 | One-clock pulse per converter oscillator cycle |
| uv_below | input | 1 | Comparator flag: output below 70% of nominal |
| ov_above | input | 1 | Comparator flag: output over 7% above regulation |
| mode | output | 2 | 0 off, 1 running, 2 undervoltage lockout, 3 crowbar |
| hs_force_off | output | 1 | Holds the high-side switch off |
| ls_force_on | output | 1 | Holds the low-side switch fully on |
| ls_force_off | output | 1 | Holds the low-side switch off |
| ref_en | output | 1 | Reference enable |

## Verification
The bench sweeps the arming window at three oscillator tick rates, with the undervoltage flag held high, and requires the running mode on every cycle up to the exact trip edge. An off-by-one counter or a missing arm gate would trip a cycle early or late. It then tries to leave each fault mode by dropping the flag, by holding the pin high, by pulling the pin low and by raising the overvoltage flag during lockout. A design that used pin levels in place of edges, or that kept crowbar detection live, would leave the latched mode. Finally it sends a one-cycle overvoltage glitch, makes both flags qualify on the same edge, and re-enters the running mode to check that a stale arming count does not cut the blanking window short.

// File: rtl/buck_fault_sup_pkg.sv
package buck_fault_sup_pkg;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_RUN     = 2'd1,
    MODE_UVLO    = 2'd2,
    MODE_CROWBAR = 2'd3
  } sup_mode_e;

  typedef struct packed {
    logic hs_off;
    logic ls_on;
    logic ls_off;
    logic ref_on;
  } sup_drive_t;

  function automatic sup_drive_t drive_of(sup_mode_e m);
    sup_drive_t d;
    case (m)
      MODE_RUN:     d = '{hs_off: 1'b0, ls_on: 1'b0, ls_off: 1'b0, ref_on: 1'b1};
      MODE_CROWBAR: d = '{hs_off: 1'b1, ls_on: 1'b1, ls_off: 1'b0, ref_on: 1'b0};
      default:      d = '{hs_off: 1'b1, ls_on: 1'b0, ls_off: 1'b1, ref_on: 1'b0};
    endcase
    return d;
  endfunction

endpackage

// File: rtl/buck_fault_sup_pin.sv
module buck_fault_sup_pin #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic level,
  output logic rise
);

  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain[0] <= pin;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
      prev <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prev;

endmodule

// File: rtl/buck_fault_sup_qual.sv
module buck_fault_sup_qual #(
  parameter int NFLAG = 2,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] flags,
  output logic [NFLAG-1:0] qual
);

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    logic [DEPTH-1:0] hist;

    always_ff @(posedge clk) begin
      if (rst) begin
        hist <= '0;
      end else begin
        hist[0] <= flags[g];
        for (int i = 1; i < DEPTH; i++) begin
          hist[i] <= hist[i-1];
        end
      end
    end

    assign qual[g] = &hist;
  end

endmodule

// File: rtl/buck_fault_sup_arm.sv
module buck_fault_sup_arm #(
  parameter int ARM_CYCLES = 6144
) (
  input  logic clk,
  input  logic rst,
  input  logic count_en,
  input  logic tick,
  output logic armed
);

  localparam int             CW    = $clog2(ARM_CYCLES + 1);
  localparam logic [CW-1:0]  LIMIT = CW'(ARM_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !count_en) begin
      cnt <= '0;
    end else if (tick && cnt != LIMIT) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign armed = (cnt == LIMIT);

endmodule

// File: rtl/buck_fault_sup.sv
module buck_fault_sup
  import buck_fault_sup_pkg::*;
#(
  parameter int ARM_CYCLES  = 6144,
  parameter int QUAL_DEPTH  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable_pin,
  input  logic       osc_tick,
  input  logic       uv_below,
  input  logic       ov_above,
  output logic [1:0] mode,
  output logic       hs_force_off,
  output logic       ls_force_on,
  output logic       ls_force_off,
  output logic       ref_en
);

  localparam int FLAG_UV = 0;
  localparam int FLAG_OV = 1;

  sup_mode_e  state, state_nxt;
  sup_drive_t drv_q, drv_nxt;
  logic       pin_level, pin_rise, armed;
  logic [1:0] qual;

  buck_fault_sup_pin #(.STAGES(SYNC_STAGES)) u_pin (
    .clk   (clk),
    .rst   (rst),
    .pin   (enable_pin),
    .level (pin_level),
    .rise  (pin_rise)
  );

  buck_fault_sup_qual #(.NFLAG(2), .DEPTH(QUAL_DEPTH)) u_qual (
    .clk   (clk),
    .rst   (rst),
    .flags ({ov_above, uv_below}),
    .qual  (qual)
  );

  buck_fault_sup_arm #(.ARM_CYCLES(ARM_CYCLES)) u_arm (
    .clk      (clk),
    .rst      (rst),
    .count_en (state == MODE_RUN),
    .tick     (osc_tick),
    .armed    (armed)
  );

  // Priority in run: pin low, then overvoltage, then armed undervoltage.
  always_comb begin
    state_nxt = state;
    case (state)
      MODE_OFF: begin
        if (pin_level) state_nxt = MODE_RUN;
      end
      MODE_RUN: begin
        if (!pin_level)                   state_nxt = MODE_OFF;
        else if (qual[FLAG_OV])           state_nxt = MODE_CROWBAR;
        else if (qual[FLAG_UV] && armed)  state_nxt = MODE_UVLO;
      end
      MODE_UVLO, MODE_CROWBAR: begin
        if (pin_rise) state_nxt = MODE_RUN;
      end
      default: state_nxt = MODE_OFF;
    endcase
  end

  assign drv_nxt = drive_of(state_nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= MODE_OFF;
      drv_q <= drive_of(MODE_OFF);
    end else begin
      state <= state_nxt;
      drv_q <= drv_nxt;
    end
  end

  assign mode         = state;
  assign hs_force_off = drv_q.hs_off;
  assign ls_force_on  = drv_q.ls_on;
  assign ls_force_off = drv_q.ls_off;
  assign ref_en       = drv_q.ref_on;

endmodule

// File: rtl/buck_fault_sup_chk.sv
module buck_fault_sup_chk #(
  parameter int ARM_CYCLES = 6144
) (
  input logic       clk,
  input logic       rst,
  input logic       osc_tick,
  input logic       ov_above,
  input logic [1:0] mode,
  input logic       hs_force_off,
  input logic       ls_force_on,
  input logic       ls_force_off,
  input logic       ref_en
);

  localparam int            CW    = $clog2(ARM_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(ARM_CYCLES);

  logic [CW-1:0] run_ticks;

  always_ff @(posedge clk) begin
    if (rst || mode != 2'd1) begin
      run_ticks <= '0;
    end else if (osc_tick && run_ticks != LIMIT) begin
      run_ticks <= run_ticks + 1'b1;
    end
  end

  a_r1_off_drive: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0) |-> (hs_force_off && ls_force_off && !ls_force_on && !ref_en));

  a_r2_run_drive: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1) |-> (!hs_force_off && !ls_force_off && !ls_force_on && ref_en));

  a_r3_ov_seen: assert property (@(posedge clk) disable iff (rst)
    $rose(mode == 2'd3) |-> $past(ov_above));

  a_r4_uv_armed: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2 && $past(mode) == 2'd1) |-> ($past(run_ticks) == LIMIT));

  a_r5_uvlo_exit: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2) |=> (mode == 2'd2 || mode == 2'd1));

  a_r6_crowbar_drive: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd3) |-> (ls_force_on && hs_force_off && !ls_force_off && !ref_en));

  a_r7_crowbar_exit: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd3) |=> (mode == 2'd3 || mode == 2'd1));

  a_r8_uvlo_no_crowbar: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2) |=> (mode != 2'd3 && !ls_force_on));

  a_r11_ls_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ls_force_on && ls_force_off));

endmodule

bind buck_fault_sup buck_fault_sup_chk #(.ARM_CYCLES(ARM_CYCLES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .osc_tick     (osc_tick),
  .ov_above     (ov_above),
  .mode         (mode),
  .hs_force_off (hs_force_off),
  .ls_force_on  (ls_force_on),
  .ls_force_off (ls_force_off),
  .ref_en       (ref_en)
);

// File: tb/buck_fault_sup_bench.sv
module buck_fault_sup_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ARM        = 10;
  localparam int QUAL       = 2;
  localparam int SYNC       = 2;

  localparam logic [1:0] M_OFF = 2'd0;
  localparam logic [1:0] M_RUN = 2'd1;
  localparam logic [1:0] M_UV  = 2'd2;
  localparam logic [1:0] M_CB  = 2'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable_pin = 1'b0;
  logic osc_tick = 1'b0;
  logic uv_below = 1'b0;
  logic ov_above = 1'b0;
  logic [1:0] mode;
  logic hs_force_off, ls_force_on, ls_force_off, ref_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  buck_fault_sup #(
    .ARM_CYCLES (ARM),
    .QUAL_DEPTH (QUAL),
    .SYNC_STAGES(SYNC)
  ) u_buck_fault_sup (
    .clk          (clk),
    .rst          (rst),
    .enable_pin   (enable_pin),
    .osc_tick     (osc_tick),
    .uv_below     (uv_below),
    .ov_above     (ov_above),
    .mode         (mode),
    .hs_force_off (hs_force_off),
    .ls_force_on  (ls_force_on),
    .ls_force_off (ls_force_off),
    .ref_en       (ref_en)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Drive order: hs_force_off, ls_force_on, ls_force_off, ref_en
  task automatic expect_mode(input string req, input logic [1:0] m);
    logic [3:0] exp_drv;
    logic [3:0] act_drv;
    case (m)
      M_RUN:   exp_drv = 4'b0001;
      M_CB:    exp_drv = 4'b1100;
      default: exp_drv = 4'b1010;
    endcase
    act_drv = {hs_force_off, ls_force_on, ls_force_off, ref_en};
    checks++;
    if (mode !== m || act_drv !== exp_drv) begin
      failures++;
      $display("FAIL %s: actual mode=%0d drive=%b expected mode=%0d drive=%b",
               req, mode, act_drv, m, exp_drv);
    end
  endtask

  task automatic enter_run();
    enable_pin = 1'b0;
    step(SYNC + 3);
    enable_pin = 1'b1;
    step(SYNC + 1);
  endtask

  // Called right after a run entry edge; undervoltage held high throughout.
  task automatic arm_run(input int p, input string req);
    int n = 0;
    uv_below = 1'b1;
    for (int i = 0; i < ARM * p + p + 4; i++) begin
      bit trip;
      trip = (n == ARM);
      osc_tick = ((i % p) == p - 1);
      @(posedge clk);
      if (osc_tick) n++;
      @(negedge clk);
      if (trip) begin
        expect_mode(req, M_UV);
        osc_tick = 1'b0;
        return;
      end
      expect_mode(req, M_RUN);
    end
    checks++;
    failures++;
    $display("FAIL %s: actual=no trip expected=trip after %0d ticks", req, ARM);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    expect_mode("R1 reset state", M_OFF);

    // R2 run entry latency
    enable_pin = 1'b1;
    step(SYNC);
    expect_mode("R2 before entry", M_OFF);
    step(1);
    expect_mode("R2 running", M_RUN);

    // R4 arming sweep at several tick rates
    for (int p = 1; p <= 3; p++) begin
      uv_below = 1'b0;
      enter_run();
      arm_run(p, "R4 arm window");
    end

    // R5 lockout latched against pin low; R8 overvoltage ignored
    enable_pin = 1'b0;
    step(6);
    expect_mode("R5 lockout held with pin low", M_UV);
    ov_above = 1'b1;
    step(QUAL + 4);
    expect_mode("R8 overvoltage ignored in lockout", M_UV);
    ov_above = 1'b0;
    uv_below = 1'b0;
    step(2);
    expect_mode("R5 lockout held after flags clear", M_UV);
    enable_pin = 1'b1;
    step(SYNC + 1);
    expect_mode("R5 exit on pin rise", M_RUN);

    // R10 count restarts after the fault exit
    arm_run(1, "R10 rearm from zero");

    // R3 glitch rejection, then qualified overvoltage
    uv_below = 1'b0;
    enter_run();
    ov_above = 1'b1;
    step(QUAL - 1);
    ov_above = 1'b0;
    step(4);
    expect_mode("R3 short glitch ignored", M_RUN);
    ov_above = 1'b1;
    step(QUAL);
    expect_mode("R3 not yet acted", M_RUN);
    step(1);
    expect_mode("R6 crowbar before arming", M_CB);

    // R7 crowbar latching
    ov_above = 1'b0;
    step(5);
    expect_mode("R7 held after flag clears", M_CB);
    enable_pin = 1'b0;
    step(6);
    expect_mode("R7 held with pin low", M_CB);
    enable_pin = 1'b1;
    step(SYNC + 1);
    expect_mode("R7 exit on pin rise", M_RUN);

    // R9 both flags on the same edge once armed
    osc_tick = 1'b1;
    step(ARM + 2);
    expect_mode("R9 armed and running", M_RUN);
    ov_above = 1'b1;
    uv_below = 1'b1;
    step(QUAL + 1);
    expect_mode("R9 overvoltage wins", M_CB);
    ov_above = 1'b0;
    uv_below = 1'b0;
    osc_tick = 1'b0;

    // R2 shutdown from run
    enter_run();
    enable_pin = 1'b0;
    step(SYNC);
    expect_mode("R2 still running", M_RUN);
    step(1);
    expect_mode("R2 back to off", M_OFF);

    // R1 reset from running
    enter_run();
    rst = 1'b1;
    step(1);
    expect_mode("R1 reset while running", M_OFF);
    rst = 1'b0;
    step(1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule